// File: doc/BRIEF.md
# User-Level Network Port with Hardware Protection

This block sits between a processor and three logical networks: two data networks (indices 0 and 1) and one control network (index 2). Code running in user mode sends and receives messages through it without calling the operating system. Each network has its own transmit FIFO and its own user receive FIFO. To send, the caller gives a network index, a tag and a data word. The port looks the tag up in a small mapping table, checks that the caller is allowed to use it, and translates it to a destination node. It then builds an envelope of privilege flag, tag, destination and data, and places it in the transmit FIFO of the chosen network.

On the receive side, each arriving message carries a privilege flag. A user-class message (flag 0) goes into the user receive FIFO of its network. A system-class message (flag 1) goes into one small system FIFO shared by all networks, and the interrupt line stays high while that FIFO holds anything. Only privileged code can write the mapping table or clear the sticky protection-error flag. A full FIFO is never overwritten: a send to a full FIFO is refused, and arriving traffic is held back through `rx_ready`.

Top module: `ulnp_port`

## Requirements
- R1: After reset, every `tx_valid` and `usr_avail` bit is 0, `sys_irq` is 0, `snd_stat` is 2'b00, `err_flag` is 0, and every mapping entry is invalid, so a send with any tag is denied even with `priv_mode` high.
- R2: A pulse on `map_wr` writes entry `map_idx` (node `map_node`, valid `map_valid`, system-only `map_sys_only`) only if `priv_mode` is 1 in the same cycle. A write attempted with `priv_mode` 0 leaves the entry unchanged.
- R3: `snd_stat` reports each `snd_req` in the cycle after the request: 2'b01 accepted, 2'b10 busy, 2'b11 denied. It reads 2'b00 in the cycle after a cycle with no request.
- R4: An accepted send appears at the head of the transmit FIFO of `snd_net` in the next cycle. Its envelope is: `tx_sys` equal to `priv_mode` at send time, `tx_tag` equal to the tag, `tx_dest` equal to the node number stored in the tag's mapping entry, and `tx_data` equal to the data.
- R5: A send is denied if the tag's entry is invalid, or if the entry is system-only and `priv_mode` is 0, or if `snd_net` is 3 or above. A denied send injects nothing and sets `err_flag`.
- R6: `err_flag` stays set until `err_clr` is pulsed while `priv_mode` is 1. `err_clr` with `priv_mode` 0 has no effect. A denial in the same cycle as a clear wins, and the flag stays set.
- R7: When the transmit FIFO of the chosen network holds 4 entries, the send reports busy and nothing is overwritten. Messages leave each network in order. The head message and `tx_valid` are held while `tx_ready` is 0.
- R8: A user-class arrival (`rx_sys` 0) is accepted when that network's user FIFO has space. Accepted arrivals are shown in order on `usr_tag`/`usr_data` with `usr_avail` set, and each `usr_rd` pulse removes one.
- R9: While a network's user receive FIFO holds 4 entries, `rx_ready` for a user-class arrival on that network is 0. Once a message is read out, `rx_ready` returns to 1.
- R10: A system-class arrival goes only to the shared system FIFO, never to a user FIFO. When several networks offer system messages in the same cycle, the lowest-numbered one is accepted and the others see `rx_ready` 0. When the system FIFO holds 2 entries, all system arrivals see `rx_ready` 0.
- R11: `sys_irq` is 1 exactly while the system FIFO is non-empty. The head entry shows the arrival network on `sys_net` along with its tag and data, and `sys_rd` removes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| priv_mode | input | 1 | Caller runs in system mode |
| map_wr | input | 1 | Mapping-table write strobe |
| map_idx | input | 3 | Entry to write |
| map_node | input | 4 | Destination node for the entry |
| map_valid | input | 1 | Entry valid bit |
| map_sys_only | input | 1 | Entry usable only in system mode |
| snd_req | input | 1 | Send request |
| snd_net | input | 2 | Target network index |
| snd_tag | input | 3 | Message tag |
| snd_data | input | 16 | Message payload |
| snd_stat | output | 2 | Result of last cycle's request |
| err_flag | output | 1 | Sticky protection-error flag |
| err_clr | input | 1 | Clear request for err_flag |
| tx_valid | output | 3 | Per-network transmit head valid |
| tx_ready | input | 3 | Per-network link accepts head |
| tx_sys | output | 3 | Envelope privilege flag per network |
| tx_tag | output | 9 | Envelope tag, 3 bits per network |
| tx_dest | output | 12 | Translated destination, 4 bits per network |
| tx_data | output | 48 | Payload, 16 bits per network |
| rx_valid | input | 3 | Per-network arrival valid |
| rx_ready | output | 3 | Per-network arrival accepted |
| rx_sys | input | 3 | Arrival privilege flag |
| rx_tag | input | 9 | Arrival tag, 3 bits per network |
| rx_data | input | 48 | Arrival payload, 16 bits per network |
| usr_rd | input | 3 | Pop user receive FIFO per network |
| usr_avail | output | 3 | User receive FIFO non-empty per network |
| usr_tag | output | 9 | Head tag of each user receive FIFO |
| usr_data | output | 48 | Head payload of each user receive FIFO |
| sys_rd | input | 1 | Pop system FIFO |
| sys_irq | output | 1 | System message pending |
| sys_net | output | 2 | Arrival network of system head |
| sys_tag | output | 3 | Tag of system head |
| sys_data | output | 16 | Payload of system head |

## Verification
The hardest case to reach is contention on the shared system FIFO. Two networks must offer system-class messages in the same cycle, and one of them must stay refused until space opens. The stimulus holds system arrivals on networks 0 and 2 together, observes which `rx_ready` rises, keeps network 2 pending into the next cycle, and then offers a third arrival while both slots are occupied. The transmit busy path needs a network whose link is held stalled while five sends target it; a scoreboard then confirms the four accepted messages leave in order.

// File: rtl/ulnp_pkg.sv
`timescale 1ns/1ps
package ulnp_pkg;
    localparam int NET_CNT = 3;
    localparam int NET_W   = 2;
    localparam int TAG_W   = 3;
    localparam int NODE_W  = 4;
    localparam int DATA_W  = 16;
    localparam int MAP_N   = 1 << TAG_W;

    typedef struct packed {
        logic              valid;
        logic              sys_only;
        logic [NODE_W-1:0] node;
    } map_ent_t;

    typedef struct packed {
        logic              sys;
        logic [TAG_W-1:0]  tag;
        logic [NODE_W-1:0] dest;
        logic [DATA_W-1:0] data;
    } tx_env_t;

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] data;
    } rx_msg_t;

    typedef struct packed {
        logic [NET_W-1:0]  net;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] data;
    } sys_msg_t;

    typedef enum logic [1:0] {
        SND_IDLE = 2'b00,
        SND_OK   = 2'b01,
        SND_BUSY = 2'b10,
        SND_DENY = 2'b11
    } snd_stat_e;

    function automatic logic tag_permitted(map_ent_t ent, logic priv);
        return ent.valid && (priv || !ent.sys_only);
    endfunction
endpackage

// File: rtl/ulnp_fifo.sv
`timescale 1ns/1ps
module ulnp_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             full,
    output logic             empty
);
    // DEPTH must be a power of two
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW:0]      wp, rp;
    logic             do_push, do_pop;

    assign full    = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
    assign empty   = (wp == rp);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp[AW-1:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp[AW-1:0]] <= din;
    end
endmodule

// File: rtl/ulnp_map_table.sv
`timescale 1ns/1ps
module ulnp_map_table
    import ulnp_pkg::*;
#(
    parameter int ENTRIES = MAP_N
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [TAG_W-1:0] wr_idx,
    input  map_ent_t         wr_ent,
    input  logic [TAG_W-1:0] rd_idx,
    output map_ent_t         rd_ent
);
    map_ent_t tbl [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < ENTRIES; k++) tbl[k] <= '0;
        end else if (wr_en) begin
            tbl[wr_idx] <= wr_ent;
        end
    end

    assign rd_ent = tbl[rd_idx];
endmodule

// File: rtl/ulnp_sys_arb.sv
`timescale 1ns/1ps
module ulnp_sys_arb
    import ulnp_pkg::*;
#(
    parameter int N = NET_CNT
) (
    input  logic [N-1:0]     req,
    output logic [N-1:0]     grant,
    output logic [NET_W-1:0] idx
);
    // lowest index wins: scan downward, last hit is kept
    always_comb begin
        grant = '0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                idx      = NET_W'(i);
            end
        end
    end
endmodule

// File: rtl/ulnp_port.sv
`timescale 1ns/1ps
module ulnp_port
    import ulnp_pkg::*;
#(
    parameter int NETS      = NET_CNT,
    parameter int TX_DEPTH  = 4,
    parameter int RX_DEPTH  = 4,
    parameter int SYS_DEPTH = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     priv_mode,
    input  logic                     map_wr,
    input  logic [TAG_W-1:0]         map_idx,
    input  logic [NODE_W-1:0]        map_node,
    input  logic                     map_valid,
    input  logic                     map_sys_only,
    input  logic                     snd_req,
    input  logic [NET_W-1:0]         snd_net,
    input  logic [TAG_W-1:0]         snd_tag,
    input  logic [DATA_W-1:0]        snd_data,
    output logic [1:0]               snd_stat,
    output logic                     err_flag,
    input  logic                     err_clr,
    output logic [NETS-1:0]          tx_valid,
    input  logic [NETS-1:0]          tx_ready,
    output logic [NETS-1:0]          tx_sys,
    output logic [NETS*TAG_W-1:0]    tx_tag,
    output logic [NETS*NODE_W-1:0]   tx_dest,
    output logic [NETS*DATA_W-1:0]   tx_data,
    input  logic [NETS-1:0]          rx_valid,
    output logic [NETS-1:0]          rx_ready,
    input  logic [NETS-1:0]          rx_sys,
    input  logic [NETS*TAG_W-1:0]    rx_tag,
    input  logic [NETS*DATA_W-1:0]   rx_data,
    input  logic [NETS-1:0]          usr_rd,
    output logic [NETS-1:0]          usr_avail,
    output logic [NETS*TAG_W-1:0]    usr_tag,
    output logic [NETS*DATA_W-1:0]   usr_data,
    input  logic                     sys_rd,
    output logic                     sys_irq,
    output logic [NET_W-1:0]         sys_net,
    output logic [TAG_W-1:0]         sys_tag,
    output logic [DATA_W-1:0]        sys_data
);
    localparam int ENV_W = $bits(tx_env_t);
    localparam int RXM_W = $bits(rx_msg_t);
    localparam int SYS_W = $bits(sys_msg_t);

    // ---------------- mapping table ----------------
    map_ent_t wr_ent, look;
    assign wr_ent = '{valid: map_valid, sys_only: map_sys_only, node: map_node};

    ulnp_map_table #(.ENTRIES(MAP_N)) u_map (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (map_wr && priv_mode),
        .wr_idx (map_idx),
        .wr_ent (wr_ent),
        .rd_idx (snd_tag),
        .rd_ent (look)
    );

    // ---------------- send path ----------------
    logic [NETS-1:0] tx_full, tx_push;
    logic            net_ok, allowed, sel_full;
    tx_env_t         env;
    snd_stat_e       stat_nxt, stat_q;
    logic            err_q;

    assign net_ok  = int'(snd_net) < NETS;
    assign allowed = net_ok && tag_permitted(look, priv_mode);
    assign env     = '{sys: priv_mode, tag: snd_tag, dest: look.node, data: snd_data};

    always_comb begin
        sel_full = 1'b0;
        for (int i = 0; i < NETS; i++)
            if (snd_net == NET_W'(i)) sel_full = tx_full[i];
    end

    always_comb begin
        if (!snd_req)      stat_nxt = SND_IDLE;
        else if (!allowed) stat_nxt = SND_DENY;
        else if (sel_full) stat_nxt = SND_BUSY;
        else               stat_nxt = SND_OK;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= SND_IDLE;
            err_q  <= 1'b0;
        end else begin
            stat_q <= stat_nxt;
            if (stat_nxt == SND_DENY)       err_q <= 1'b1;
            else if (err_clr && priv_mode)  err_q <= 1'b0;
        end
    end

    assign snd_stat = stat_q;
    assign err_flag = err_q;

    // ---------------- system receive arbitration ----------------
    logic [NETS-1:0]  sys_req, sys_grant;
    logic [NET_W-1:0] sys_idx;
    logic             sys_full, sys_empty, sys_push;
    sys_msg_t         sys_din, sys_head;

    assign sys_req = rx_valid & rx_sys;

    ulnp_sys_arb #(.N(NETS)) u_arb (
        .req   (sys_req),
        .grant (sys_grant),
        .idx   (sys_idx)
    );

    always_comb begin
        sys_din = '0;
        for (int i = 0; i < NETS; i++) begin
            if (sys_grant[i]) begin
                sys_din.net  = sys_idx;
                sys_din.tag  = rx_tag[i*TAG_W +: TAG_W];
                sys_din.data = rx_data[i*DATA_W +: DATA_W];
            end
        end
    end

    assign sys_push = |sys_req;

    ulnp_fifo #(.WIDTH(SYS_W), .DEPTH(SYS_DEPTH)) u_sys_q (
        .clk   (clk),
        .rst   (rst),
        .push  (sys_push),
        .din   (sys_din),
        .pop   (sys_rd),
        .dout  (sys_head),
        .full  (sys_full),
        .empty (sys_empty)
    );

    assign sys_irq  = !sys_empty;
    assign sys_net  = sys_head.net;
    assign sys_tag  = sys_head.tag;
    assign sys_data = sys_head.data;

    // ---------------- per-network queues ----------------
    for (genvar g = 0; g < NETS; g++) begin : g_net
        tx_env_t tx_head;
        rx_msg_t rx_din, rx_head;
        logic    tx_empty, usr_full, usr_empty;

        assign tx_push[g] = snd_req && allowed && (snd_net == NET_W'(g)) && !tx_full[g];

        ulnp_fifo #(.WIDTH(ENV_W), .DEPTH(TX_DEPTH)) u_tx_q (
            .clk   (clk),
            .rst   (rst),
            .push  (tx_push[g]),
            .din   (env),
            .pop   (tx_ready[g]),
            .dout  (tx_head),
            .full  (tx_full[g]),
            .empty (tx_empty)
        );

        assign tx_valid[g]                     = !tx_empty;
        assign tx_sys[g]                       = tx_head.sys;
        assign tx_tag[g*TAG_W +: TAG_W]        = tx_head.tag;
        assign tx_dest[g*NODE_W +: NODE_W]     = tx_head.dest;
        assign tx_data[g*DATA_W +: DATA_W]     = tx_head.data;

        assign rx_din = '{tag: rx_tag[g*TAG_W +: TAG_W], data: rx_data[g*DATA_W +: DATA_W]};

        ulnp_fifo #(.WIDTH(RXM_W), .DEPTH(RX_DEPTH)) u_usr_q (
            .clk   (clk),
            .rst   (rst),
            .push  (rx_valid[g] && !rx_sys[g]),
            .din   (rx_din),
            .pop   (usr_rd[g]),
            .dout  (rx_head),
            .full  (usr_full),
            .empty (usr_empty)
        );

        assign rx_ready[g]                 = rx_sys[g] ? (sys_grant[g] && !sys_full) : !usr_full;
        assign usr_avail[g]                = !usr_empty;
        assign usr_tag[g*TAG_W +: TAG_W]   = rx_head.tag;
        assign usr_data[g*DATA_W +: DATA_W] = rx_head.data;
    end
endmodule

// File: rtl/ulnp_port_chk.sv
`timescale 1ns/1ps
module ulnp_port_chk
    import ulnp_pkg::*;
#(
    parameter int NETS = NET_CNT
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   priv_mode,
    input logic                   snd_req,
    input logic [1:0]             snd_stat,
    input logic                   err_flag,
    input logic                   err_clr,
    input logic [NETS-1:0]        tx_valid,
    input logic [NETS-1:0]        tx_ready,
    input logic [NETS*DATA_W-1:0] tx_data,
    input logic [NETS-1:0]        rx_valid,
    input logic [NETS-1:0]        rx_sys,
    input logic [NETS-1:0]        rx_ready,
    input logic                   sys_irq,
    input logic                   sys_rd
);
    AST_STAT_IDLE: assert property (@(posedge clk) disable iff (rst)
        !snd_req |=> snd_stat == SND_IDLE); // R3

    AST_DENY_SETS_ERR: assert property (@(posedge clk) disable iff (rst)
        snd_stat == SND_DENY |-> err_flag); // R5

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        err_flag && !(err_clr && priv_mode) |=> err_flag); // R6

    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        sys_irq && !sys_rd |=> sys_irq); // R11

    for (genvar g = 0; g < NETS; g++) begin : g_chk
        AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
            tx_valid[g] && !tx_ready[g] |=> tx_valid[g] && $stable(tx_data[g*DATA_W +: DATA_W])); // R7

        AST_SYS_RAISES_IRQ: assert property (@(posedge clk) disable iff (rst)
            rx_valid[g] && rx_sys[g] && rx_ready[g] |=> sys_irq); // R10
    end
endmodule

bind ulnp_port ulnp_port_chk #(.NETS(NETS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .priv_mode (priv_mode),
    .snd_req   (snd_req),
    .snd_stat  (snd_stat),
    .err_flag  (err_flag),
    .err_clr   (err_clr),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_data   (tx_data),
    .rx_valid  (rx_valid),
    .rx_sys    (rx_sys),
    .rx_ready  (rx_ready),
    .sys_irq   (sys_irq),
    .sys_rd    (sys_rd)
);

// File: tb/ulnp_port_test.sv
`timescale 1ns/1ps
module ulnp_port_test;
    import ulnp_pkg::*;
    localparam int N = NET_CNT;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst, priv_mode, map_wr, map_valid, map_sys_only, snd_req, err_clr, err_flag, sys_rd, sys_irq;
    logic [TAG_W-1:0]  map_idx, snd_tag, sys_tag;
    logic [NODE_W-1:0] map_node;
    logic [NET_W-1:0]  snd_net, sys_net;
    logic [DATA_W-1:0] snd_data, sys_data;
    logic [1:0]        snd_stat;
    logic [N-1:0]      tx_valid, tx_ready, tx_sys, rx_valid, rx_ready, rx_sys, usr_rd, usr_avail;
    logic [N*TAG_W-1:0]  tx_tag, rx_tag, usr_tag;
    logic [N*NODE_W-1:0] tx_dest;
    logic [N*DATA_W-1:0] tx_data, rx_data, usr_data;

    ulnp_port uut (.*);

    int checks = 0, failures = 0;
    tx_env_t exp_q [N][$];
    logic [NODE_W-1:0] mdl_node [MAP_N];

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic map_write(input logic pv, input int idx, input int node, input logic vld, input logic so);
        priv_mode = pv; map_wr = 1; map_idx = TAG_W'(idx); map_node = NODE_W'(node);
        map_valid = vld; map_sys_only = so;
        step();
        map_wr = 0; priv_mode = 0;
        if (pv) mdl_node[idx] = NODE_W'(node);
    endtask

    // driver: issues a send, checks the status, queues the expected envelope
    task automatic do_send(input logic pv, input int net, input int tag, input int data,
                           input logic [1:0] exp_stat, input string req);
        tx_env_t e;
        priv_mode = pv; snd_req = 1; snd_net = NET_W'(net); snd_tag = TAG_W'(tag); snd_data = DATA_W'(data);
        step();
        snd_req = 0; priv_mode = 0;
        check(snd_stat == exp_stat, req, "snd_stat", snd_stat, exp_stat);
        if (exp_stat == SND_OK) begin
            e = '{sys: pv, tag: TAG_W'(tag), dest: mdl_node[tag], data: DATA_W'(data)};
            exp_q[net].push_back(e);
        end
    endtask

    task automatic rx_drive(input int net, input logic sy, input int tag, input int data,
                            input logic exp_rdy, input string req);
        rx_valid[net] = 1; rx_sys[net] = sy;
        rx_tag[net*TAG_W +: TAG_W] = TAG_W'(tag);
        rx_data[net*DATA_W +: DATA_W] = DATA_W'(data);
        #1;
        check(rx_ready[net] == exp_rdy, req, "rx_ready", rx_ready[net], exp_rdy);
        @(posedge clk); #1;
        rx_valid[net] = 0; rx_sys[net] = 0;
    endtask

    task automatic usr_take(input int net, input int tag, input int data, input string req);
        check(usr_avail[net] == 1'b1, req, "usr_avail", usr_avail[net], 1);
        check(usr_tag[net*TAG_W +: TAG_W] == TAG_W'(tag), req, "usr_tag", usr_tag[net*TAG_W +: TAG_W], tag);
        check(usr_data[net*DATA_W +: DATA_W] == DATA_W'(data), req, "usr_data", usr_data[net*DATA_W +: DATA_W], data);
        usr_rd[net] = 1; step(); usr_rd[net] = 0;
    endtask

    // monitor: compares every transmit handshake with the scoreboard (R4, R7)
    always @(negedge clk) begin
        if (!rst) begin
            for (int i = 0; i < N; i++) begin
                if (tx_valid[i] && tx_ready[i]) begin
                    tx_env_t got, e;
                    got = '{sys: tx_sys[i], tag: tx_tag[i*TAG_W +: TAG_W],
                            dest: tx_dest[i*NODE_W +: NODE_W], data: tx_data[i*DATA_W +: DATA_W]};
                    if (exp_q[i].size() == 0) begin
                        check(1'b0, "R4", "unexpected tx envelope", int'(got), 0);
                    end else begin
                        e = exp_q[i].pop_front();
                        check(got == e, "R4", "tx envelope", int'(got), int'(e));
                    end
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog", "run timed out", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1; priv_mode = 0; map_wr = 0; map_idx = 0; map_node = 0; map_valid = 0; map_sys_only = 0;
        snd_req = 0; snd_net = 0; snd_tag = 0; snd_data = 0; err_clr = 0; sys_rd = 0;
        tx_ready = '0; rx_valid = '0; rx_sys = '0; rx_tag = '0; rx_data = '0; usr_rd = '0;
        for (int k = 0; k < MAP_N; k++) mdl_node[k] = '0;
        repeat (3) step();
        rst = 0;
        step();

        // R1 reset state
        check(tx_valid == '0, "R1", "tx_valid", tx_valid, 0);
        check(usr_avail == '0, "R1", "usr_avail", usr_avail, 0);
        check(sys_irq == 1'b0, "R1", "sys_irq", sys_irq, 0);
        check(snd_stat == SND_IDLE, "R1", "snd_stat", snd_stat, 0);
        check(err_flag == 1'b0, "R1", "err_flag", err_flag, 0);
        do_send(1, 0, 0, 16'h0001, SND_DENY, "R1");
        check(err_flag == 1'b1, "R5", "err_flag after deny", err_flag, 1);
        step();
        check(snd_stat == SND_IDLE, "R3", "idle status", snd_stat, 0);

        // R6 clear needs system mode
        err_clr = 1; step(); err_clr = 0;
        check(err_flag == 1'b1, "R6", "user clear ignored", err_flag, 1);
        priv_mode = 1; err_clr = 1; step(); err_clr = 0; priv_mode = 0;
        check(err_flag == 1'b0, "R6", "system clear", err_flag, 0);

        // R2 user write ignored
        map_write(0, 1, 7, 1, 0);
        do_send(1, 0, 1, 16'h0002, SND_DENY, "R2");
        priv_mode = 1; err_clr = 1; step(); err_clr = 0; priv_mode = 0;

        map_write(1, 1, 5, 1, 0);
        map_write(1, 2, 9, 1, 1);
        map_write(1, 3, 12, 1, 0);
        tx_ready = '1;

        // R4 translation and envelope
        do_send(0, 0, 1, 16'hA1A1, SND_OK, "R4");
        do_send(0, 2, 3, 16'hC3C3, SND_OK, "R4");
        do_send(1, 2, 2, 16'h5A5A, SND_OK, "R4");
        step(); step();

        // R5 protection denials
        do_send(0, 1, 2, 16'hBAD0, SND_DENY, "R5");
        check(err_flag == 1'b1, "R5", "err_flag sys-only", err_flag, 1);
        do_send(0, 3, 1, 16'hBAD1, SND_DENY, "R5");
        // R6 deny beats a same-cycle clear
        err_clr = 1;
        do_send(1, 3, 1, 16'hBAD2, SND_DENY, "R6");
        err_clr = 0;
        check(err_flag == 1'b1, "R6", "deny wins over clear", err_flag, 1);
        step(); step();

        // R7 busy on full transmit FIFO
        tx_ready[1] = 0;
        for (int k = 0; k < 4; k++) do_send(0, 1, 3, 16'h7000 + k, SND_OK, "R7");
        do_send(0, 1, 3, 16'h7FFF, SND_BUSY, "R7");
        step(); step();
        check(tx_valid[1] == 1'b1, "R7", "head held valid", tx_valid[1], 1);
        check(tx_data[DATA_W +: DATA_W] == 16'h7000, "R7", "head held data", tx_data[DATA_W +: DATA_W], 16'h7000);
        tx_ready[1] = 1;
        repeat (8) step();
        for (int i = 0; i < N; i++)
            check(exp_q[i].size() == 0, "R7", "queue drained", exp_q[i].size(), 0);

        // R8 user receive
        rx_drive(1, 0, 5, 16'h1111, 1, "R8");
        usr_take(1, 5, 16'h1111, "R8");
        check(usr_avail[1] == 1'b0, "R8", "usr_avail after read", usr_avail[1], 0);

        // R9 backpressure on full user FIFO
        for (int k = 0; k < 4; k++) rx_drive(0, 0, k, 16'h2000 + k, 1, "R9");
        rx_drive(0, 0, 4, 16'h2004, 0, "R9");
        usr_take(0, 0, 16'h2000, "R8");
        rx_drive(0, 0, 4, 16'h2004, 1, "R9");
        for (int k = 1; k < 5; k++) usr_take(0, k, 16'h2000 + k, "R8");

        // R10 system arrivals, contention and full
        rx_valid = 3'b101; rx_sys = 3'b101;
        rx_tag[0 +: TAG_W] = 3'd6; rx_data[0 +: DATA_W] = 16'h5001;
        rx_tag[2*TAG_W +: TAG_W] = 3'd7; rx_data[2*DATA_W +: DATA_W] = 16'h5002;
        #1;
        check(rx_ready[0] == 1'b1, "R10", "lowest net granted", rx_ready[0], 1);
        check(rx_ready[2] == 1'b0, "R10", "higher net held", rx_ready[2], 0);
        @(posedge clk); #1;
        rx_valid[0] = 0; rx_sys[0] = 0;
        #1;
        check(rx_ready[2] == 1'b1, "R10", "held net granted next", rx_ready[2], 1);
        @(posedge clk); #1;
        rx_valid = '0; rx_sys = '0;
        check(sys_irq == 1'b1, "R11", "irq raised", sys_irq, 1);
        check(usr_avail == '0, "R10", "no user delivery", usr_avail, 0);
        rx_drive(1, 1, 1, 16'h5003, 0, "R10");

        // R11 drain system FIFO
        check(sys_net == 2'd0 && sys_tag == 3'd6 && sys_data == 16'h5001, "R11", "sys head 1", sys_data, 16'h5001);
        step();
        check(sys_irq == 1'b1, "R11", "irq held without read", sys_irq, 1);
        sys_rd = 1; step(); sys_rd = 0;
        check(sys_irq == 1'b1, "R11", "irq while one left", sys_irq, 1);
        check(sys_net == 2'd2 && sys_tag == 3'd7 && sys_data == 16'h5002, "R11", "sys head 2", sys_data, 16'h5002);
        sys_rd = 1; step(); sys_rd = 0;
        check(sys_irq == 1'b0, "R11", "irq cleared when empty", sys_irq, 0);

        step();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule